// File: doc/BRIEF.md
# Six-Line Prioritised Vectored Interrupt Controller

This block collects six interrupt request lines into one pending-request register, filters them through a per-line and global enable byte, and arbitrates among the survivors in an order chosen by software. Hardware events set request bits. Software can also load the request register directly, either to raise an interrupt on purpose or to acknowledge one it has polled.

The CPU raises a sample strobe at each instruction boundary. On that strobe the controller chooses the highest-ranked request that is both pending and enabled. It then emits a one-cycle grant together with the request index and that request's 16-bit vector table address. In the same step it clears the serviced request bit and the global enable, so no further interrupt is taken until software turns the global enable back on.

For polled operation, software leaves the enables off and reads the request register, which the controller never changes on its own while nothing is enabled. One bit of the enable byte is a memory-protect switch that is brought out on its own pin and takes no part in arbitration.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset, the request register, the enable byte, the priority code, grant, grant index, vector address and protect output are all zero.
- R2: A high bit in `hw_set` sets the matching request bit at the next clock edge. A write with `wr_sel`=0 loads `wr_data[5:0]` into the request register.
- R3: When a hardware set and a software write of 0 hit the same request bit in the same cycle, the bit ends set. A hardware set arriving in the same cycle as the grant that would clear that bit also leaves it set.
- R4: No grant is issued in any cycle unless `sample` was high at the previous clock edge.
- R5: A request competes only if its request bit is set, its enable bit (enable byte bit n for request n) is set, and the global enable (enable byte bit 7) is set. A request that does not compete stays pending in the request register.
- R6: A write with `wr_sel`=2 loads `wr_data[2:0]` as the priority code. For code c from 0 to 5, request c ranks highest, followed by c+1, c+2 and so on, wrapping from 5 back to 0. Codes 6 and 7 rank the requests in ascending index order, the same as code 0.
- R7: A strobe that finds a competing request raises `grant` for exactly one cycle after that edge. At the same time it drives the winner's index on `grant_idx` and the value 2×index on `vec_addr`. Both values hold until the next grant.
- R8: A grant clears only the winning request bit and enable byte bit 7. Every other request bit and enable bit keeps its value.
- R9: A write with `wr_sel`=1 loads the whole enable byte. Bit 6 drives `protect_en` and has no effect on which request wins.
- R10: With the global enable off, a strobe issues no grant and leaves the request register unchanged, so software can poll it.
- R11: A write with `wr_sel`=3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_set | input | 6 | Per-line hardware request set pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 request, 1 enable byte, 2 priority code, 3 none |
| wr_data | input | 8 | Write data |
| sample | input | 1 | Instruction-boundary arbitration strobe |
| req_q | output | 6 | Pending request register |
| mask_q | output | 8 | Enable byte (bit 7 global, bit 6 protect, bits 5..0 per line) |
| prio_q | output | 3 | Priority code |
| protect_en | output | 1 | Memory protect enable (enable byte bit 6) |
| grant | output | 1 | One-cycle interrupt grant |
| grant_idx | output | 3 | Index of the granted request |
| vec_addr | output | 16 | Vector table address of the granted request |

## Verification
The assertions assume that `hw_set`, `sample` and the write inputs are held at zero while reset is asserted. They also assume that these inputs change only away from the rising clock edge. The stimulus drives every input on the falling edge and keeps them all quiet through reset. The grant checks assume that the enable byte is not rewritten in the cycle the grant appears. The stimulus always waits for each grant to be observed before it writes the enable byte again.

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       hw_set,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             sample,
  output logic [5:0]       req_q,
  output logic [7:0]       mask_q,
  output logic [2:0]       prio_q,
  output logic             protect_en,
  output logic             grant,
  output logic [2:0]       grant_idx,
  output logic [VEC_W-1:0] vec_addr
);
  localparam int NREQ = 6;

  logic [NREQ-1:0] pend, clr, req_base, req_nxt;
  logic [7:0]      mask_nxt;
  logic [2:0]      start, win;
  logic [3:0]      pos;
  logic            found, fire;

  assign pend       = req_q & mask_q[NREQ-1:0] & {NREQ{mask_q[7]}};
  assign start      = (prio_q < 3'(NREQ)) ? prio_q : 3'd0;
  assign protect_en = mask_q[6];

  always_comb begin
    found = 1'b0;
    win   = 3'd0;
    pos   = 4'd0;
    for (int k = 0; k < NREQ; k++) begin
      pos = {1'b0, start} + 4'(k);
      if (pos >= 4'(NREQ)) pos = pos - 4'(NREQ);
      if (!found && pend[pos[2:0]]) begin
        found = 1'b1;
        win   = pos[2:0];
      end
    end
  end

  assign fire = sample & found;
  assign clr  = fire ? (NREQ'(1) << win) : '0;

  always_comb begin
    req_base = (wr_en && wr_sel == 2'd0) ? wr_data[NREQ-1:0] : (req_q & ~clr);
    req_nxt  = req_base | hw_set;
    mask_nxt = (wr_en && wr_sel == 2'd1) ? wr_data : mask_q;
    if (fire) mask_nxt[7] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= '0;
      mask_q    <= '0;
      prio_q    <= '0;
      grant     <= 1'b0;
      grant_idx <= '0;
      vec_addr  <= '0;
    end else begin
      req_q  <= req_nxt;
      mask_q <= mask_nxt;
      if (wr_en && wr_sel == 2'd2) prio_q <= wr_data[2:0];
      grant <= fire;
      if (fire) begin
        grant_idx <= win;
        vec_addr  <= VEC_W'({win, 1'b0});
      end
    end
  end

  a_r4_grant_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(sample));

  a_r5_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ((($past(pend) >> grant_idx) & 6'd1) != 6'd0));

  a_r8_global_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !mask_q[7]);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(hw_set) & ~req_q) == 6'd0));

  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (grant_idx < 3'(NREQ)));
endmodule

// File: tb/irq_vector_ctl_bench.sv
module irq_vector_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  hw_set = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        sample = 1'b0;
  logic [5:0]  req_q;
  logic [7:0]  mask_q;
  logic [2:0]  prio_q;
  logic        protect_en, grant;
  logic [2:0]  grant_idx;
  logic [15:0] vec_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctl u_irq_vector_ctl (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sample(sample), .req_q(req_q), .mask_q(mask_q),
    .prio_q(prio_q), .protect_en(protect_en), .grant(grant),
    .grant_idx(grant_idx), .vec_addr(vec_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected grant index for every grant seen
  always @(negedge clk) begin
    if (rst_n && grant) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected grant", grant_idx, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(grant_idx == 3'(e), "R7 grant index", grant_idx, e);
        chk(vec_addr == 16'(2*e), "R7 vector address", vec_addr, 2*e);
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic strobe(input bit exp_valid, input int idx, input string req);
    @(negedge clk); sample = 1'b1;
    if (exp_valid) exp_q.push_back(idx);
    @(negedge clk); sample = 1'b0;
    chk(grant == exp_valid, req, grant, exp_valid);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_q == 0 && mask_q == 0 && prio_q == 0, "R1 registers", {req_q, mask_q, prio_q}, 0);
    chk(!grant && grant_idx == 0 && vec_addr == 0 && !protect_en, "R1 outputs", vec_addr, 0);

    // R2 hardware set, then software load
    @(negedge clk); hw_set = 6'b000100;
    @(negedge clk); hw_set = '0;
    chk(req_q == 6'b000100, "R2 hw set", req_q, 6'b000100);
    wr(2'd0, 8'h21);
    chk(req_q == 6'h21, "R2 sw load", req_q, 6'h21);

    // R3 hw set beats same-cycle software clear
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h00; hw_set = 6'b001000;
    @(negedge clk); wr_en = 1'b0; hw_set = '0;
    chk(req_q == 6'b001000, "R3 set wins over write", req_q, 6'b001000);

    // R11 select 3 ignored
    wr(2'd3, 8'hff);
    chk(req_q == 6'b001000 && mask_q == 0 && prio_q == 0, "R11 no effect",
        {req_q, mask_q, prio_q}, {6'b001000, 8'h00, 3'd0});

    // R10 polling with global off
    wr(2'd0, 8'h3f);
    wr(2'd1, 8'h3f);
    strobe(1'b0, 0, "R10 no grant when global off");
    chk(req_q == 6'h3f, "R10 request unchanged", req_q, 6'h3f);

    // R5 global on, no per-line enables
    wr(2'd1, 8'h80);
    strobe(1'b0, 0, "R5 no grant without line enable");
    chk(req_q == 6'h3f, "R5 request stays pending", req_q, 6'h3f);

    // R9 protect bit; R6 code 0
    wr(2'd1, 8'hff);
    chk(protect_en == 1'b1, "R9 protect output", protect_en, 1);
    strobe(1'b1, 0, "R6 code0 grant");
    chk(req_q == 6'h3e, "R8 only winner cleared", req_q, 6'h3e);
    chk(mask_q == 8'h7f, "R8 global enable dropped", mask_q, 8'h7f);

    // R4 no grant without strobe (global off anyway, re-enable first)
    wr(2'd1, 8'hff);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!grant, "R4 no grant without sample", grant, 0);
    end
    chk(req_q == 6'h3e, "R4 request untouched", req_q, 6'h3e);

    // R7 hold of index/vector
    chk(grant_idx == 0 && vec_addr == 0, "R7 hold after grant", vec_addr, 0);

    // R6 code 3
    wr(2'd2, 8'h03);
    chk(prio_q == 3'd3, "R6 code load", prio_q, 3);
    wr(2'd0, 8'h3f);
    strobe(1'b1, 3, "R6 code3 grant");
    chk(req_q == 6'h37, "R8 bit3 cleared", req_q, 6'h37);

    // R6 code 5
    wr(2'd2, 8'h05);
    wr(2'd1, 8'hff);
    strobe(1'b1, 5, "R6 code5 grant");
    chk(grant_idx == 3'd5, "R7 index held", grant_idx, 5);

    // R6 code 7 fallback to ascending
    wr(2'd2, 8'h07);
    wr(2'd0, 8'h24);
    wr(2'd1, 8'hff);
    strobe(1'b1, 2, "R6 code7 fallback");

    // R6 code 4 wraps
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'hff);
    strobe(1'b1, 0, "R6 code4 wrap");

    // R5 per-line mask; R9 bit6 clear still arbitrates
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h82);
    chk(protect_en == 1'b0, "R9 protect off", protect_en, 0);
    strobe(1'b1, 1, "R5 masked line skipped");
    chk(req_q == 6'h01, "R5 masked stays pending", req_q, 6'h01);

    // R3 hw set during grant of same bit
    wr(2'd1, 8'h81);
    @(negedge clk); sample = 1'b1; hw_set = 6'b000001; exp_q.push_back(0);
    @(negedge clk); sample = 1'b0; hw_set = '0;
    chk(grant == 1'b1, "R3 grant issued", grant, 1);
    chk(req_q == 6'h01, "R3 set survives grant", req_q, 6'h01);

    @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R7 all grants seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule